// File: doc/BRIEF.md
# Endpoint Data Toggle Synchronizer

This block keeps one sequence bit for each endpoint of a packet-based serial bus function. The bit tells new data apart from a retransmission. On the receive side it judges each decoded data packet and chooses the handshake. A packet is ACKed and committed when it is new. It is ACKed and discarded when it repeats a packet already taken. It is NAKed when it is damaged or when the buffer cannot take it. On the transmit side it names the data PID for the chosen endpoint and advances the bit only when a valid ACK closes the handshake window.

Clearing events act at any time. A SETUP event zeroes the bit of the addressed control endpoint. A configuration event zeroes the bits of every bulk and interrupt endpoint. Isochronous endpoints take no part in sequencing: they get no handshake and always send DATA0.

A small controller sequences the work. Its states are `S_IDLE`, `S_RX_RESP` and `S_TX_WAIT`, with these transitions:
- `S_IDLE` to `S_RX_RESP` on `rx_valid_i`.
- `S_IDLE` to `S_TX_WAIT` on `tx_start_i` when no packet is present. Receive wins if both are raised.
- `S_RX_RESP` back to `S_IDLE` after one cycle.
- `S_TX_WAIT` back to `S_IDLE` on `hs_done_i`.

Top module: `ep_seq_sync`

## Requirements
- R1: A synchronous reset clears every sequence bit to 0, puts the controller in `S_IDLE`, and drives `hs_o`=2'b00, `acc_o`=0 and `dis_o`=0.
- R2: `tx_pid_o` is 4'b0011 (DATA0) when the bit of endpoint `tx_ep_i` is 0 and 4'b1011 (DATA1) when it is 1. Bit 3 of a data PID carries the sequence value. Any isochronous endpoint always gives 4'b0011.
- R3: A packet that meets all of the following raises `acc_o` and `hs_o`=2'b01 (ACK) in the cycle after `rx_valid_i`, and flips the endpoint's bit at that same edge:
  - it arrives on a non-isochronous endpoint;
  - its CRC is good;
  - its data PID matches the stored bit;
  - `buf_rdy_i`=1.
- R4: A packet with a bad CRC, or with a PID that is neither data PID, gives `hs_o`=2'b10 (NAK) and `dis_o`. The bit is left unchanged.
- R5: An error-free packet whose data PID differs from the stored bit gives ACK with `dis_o` and not `acc_o`. The bit is left unchanged. This holds even when the buffer is not ready.
- R6: A valid packet with the expected PID while `buf_rdy_i`=0 gives NAK and `dis_o`. The bit is left unchanged.
- R7: `setup_i` clears the bit of endpoint `setup_ep_i` only if that endpoint is control (type code 2'b00). It has no effect on other types.
- R8: `cfg_i` clears the bits of all bulk (2'b10) and interrupt (2'b11) endpoints. Control bits are left unchanged.
- R9: On an isochronous endpoint (2'b01) a received packet gives `hs_o`=2'b00. It raises `acc_o` if the CRC is good and `dis_o` otherwise. Its bit never changes.
- R10: In `S_TX_WAIT` the bit of the latched endpoint flips only when `hs_done_i` and `hs_ack_i` are both high. A window that closes without a valid ACK keeps the same PID for the retry.
- R11: `rx_valid_i` outside `S_IDLE` is ignored. It produces no strobe, no handshake and no change to any bit.
- R12: `acc_o` and `dis_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_types_i | input | 2*N_EP | Type code per endpoint, endpoint i in bits [2i+1:2i] |
| rx_valid_i | input | 1 | Decoded data packet present |
| rx_ep_i | input | EPW | Endpoint of received packet |
| rx_pid_i | input | 4 | Decoded PID of received packet |
| rx_crc_ok_i | input | 1 | Packet passed CRC |
| buf_rdy_i | input | 1 | Endpoint buffer can take the payload |
| tx_start_i | input | 1 | Start of a data transmission |
| tx_ep_i | input | EPW | Endpoint for transmission and PID lookup |
| hs_done_i | input | 1 | Handshake window closed |
| hs_ack_i | input | 1 | A valid ACK was received in that window |
| setup_i | input | 1 | SETUP event |
| setup_ep_i | input | EPW | Endpoint addressed by SETUP |
| cfg_i | input | 1 | Configuration event |
| hs_o | output | 2 | Handshake to send: 00 none, 01 ACK, 10 NAK |
| acc_o | output | 1 | Commit payload strobe |
| dis_o | output | 1 | Drop payload strobe |
| tx_pid_o | output | 4 | Data PID for endpoint tx_ep_i |

## Verification
A wrong sequence bit does not show at the ports when it goes wrong. It shows later:
- as a flipped `tx_pid_o` as soon as the endpoint is selected for transmission;
- as a swapped accept/discard verdict on the next packet to that endpoint, one cycle after `rx_valid_i`.

The bench therefore reads the bit back through `tx_pid_o` right after every event. It also follows each damaged, repeated or refused packet with one that proves the bit held.

// File: rtl/ep_seq_pkg.sv
package ep_seq_pkg;
    typedef enum logic [1:0] {
        EPT_CTRL = 2'd0,
        EPT_ISO  = 2'd1,
        EPT_BULK = 2'd2,
        EPT_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_e;

    typedef enum logic [2:0] {
        V_NEW, V_DUP, V_BAD, V_BUSY, V_ISO_OK, V_ISO_BAD
    } verdict_e;

    typedef enum logic [1:0] {
        S_IDLE, S_RX_RESP, S_TX_WAIT
    } fsm_e;

    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;
endpackage

// File: rtl/ep_seq_judge.sv
module ep_seq_judge
    import ep_seq_pkg::*;
(
    input  logic [3:0] pid_i,
    input  logic       crc_ok_i,
    input  logic       buf_rdy_i,
    input  logic       tog_i,
    input  logic       iso_i,
    output verdict_e   verdict_o
);
    logic is_data;
    logic seq_bit;

    assign is_data = (pid_i == PID_DATA0) || (pid_i == PID_DATA1);
    assign seq_bit = pid_i[3];

    always_comb begin
        if (iso_i) begin
            verdict_o = (crc_ok_i && is_data) ? V_ISO_OK : V_ISO_BAD;
        end else if (!crc_ok_i || !is_data) begin
            verdict_o = V_BAD;
        end else if (seq_bit != tog_i) begin
            verdict_o = V_DUP;
        end else if (!buf_rdy_i) begin
            verdict_o = V_BUSY;
        end else begin
            verdict_o = V_NEW;
        end
    end
endmodule

// File: rtl/ep_seq_bank.sv
module ep_seq_bank
    import ep_seq_pkg::*;
#(
    parameter int N_EP = 4,
    parameter int EPW  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2*N_EP-1:0] types_i,
    input  logic              flip_en_i,
    input  logic [EPW-1:0]    flip_ep_i,
    input  logic              setup_clr_i,
    input  logic [EPW-1:0]    setup_ep_i,
    input  logic              cfg_clr_i,
    output logic [N_EP-1:0]   tog_o,
    output logic [N_EP-1:0]   iso_o
);
    for (genvar i = 0; i < N_EP; i++) begin : g_ep
        ep_kind_e kind;
        logic     tog_q;
        logic     is_bi;
        logic     clr;

        assign kind     = ep_kind_e'(types_i[2*i +: 2]);
        assign is_bi    = (kind == EPT_BULK) || (kind == EPT_INTR);
        assign clr      = (cfg_clr_i && is_bi) ||
                          (setup_clr_i && (setup_ep_i == EPW'(i)) && (kind == EPT_CTRL));
        assign iso_o[i] = (kind == EPT_ISO);
        assign tog_o[i] = tog_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                tog_q <= 1'b0;
            end else if (clr) begin
                tog_q <= 1'b0;
            end else if (flip_en_i && (flip_ep_i == EPW'(i)) && (kind != EPT_ISO)) begin
                tog_q <= ~tog_q;
            end
        end

        // R8
        cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_clr_i && is_bi) |=> !tog_q);

        // R9
        iso_fixed_chk: assert property (@(posedge clk) disable iff (rst)
            (kind == EPT_ISO && $past(kind) == EPT_ISO) |-> $stable(tog_q));
    end
endmodule

// File: rtl/ep_seq_sync.sv
module ep_seq_sync
    import ep_seq_pkg::*;
#(
    parameter int N_EP = 4,
    localparam int EPW = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2*N_EP-1:0] ep_types_i,
    input  logic              rx_valid_i,
    input  logic [EPW-1:0]    rx_ep_i,
    input  logic [3:0]        rx_pid_i,
    input  logic              rx_crc_ok_i,
    input  logic              buf_rdy_i,
    input  logic              tx_start_i,
    input  logic [EPW-1:0]    tx_ep_i,
    input  logic              hs_done_i,
    input  logic              hs_ack_i,
    input  logic              setup_i,
    input  logic [EPW-1:0]    setup_ep_i,
    input  logic              cfg_i,
    output logic [1:0]        hs_o,
    output logic              acc_o,
    output logic              dis_o,
    output logic [3:0]        tx_pid_o
);
    fsm_e           state_q, state_d;
    verdict_e       verdict_q, verdict_now;
    logic [EPW-1:0] tx_ep_q;
    logic [N_EP-1:0] tog, iso;
    logic           flip_en;
    logic [EPW-1:0] flip_ep;
    hs_e            hs;

    ep_seq_judge u_judge (
        .pid_i     (rx_pid_i),
        .crc_ok_i  (rx_crc_ok_i),
        .buf_rdy_i (buf_rdy_i),
        .tog_i     (tog[rx_ep_i]),
        .iso_i     (iso[rx_ep_i]),
        .verdict_o (verdict_now)
    );

    assign flip_en = ((state_q == S_IDLE) && rx_valid_i && (verdict_now == V_NEW)) ||
                     ((state_q == S_TX_WAIT) && hs_done_i && hs_ack_i);
    assign flip_ep = (state_q == S_IDLE) ? rx_ep_i : tx_ep_q;

    ep_seq_bank #(.N_EP(N_EP), .EPW(EPW)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .types_i     (ep_types_i),
        .flip_en_i   (flip_en),
        .flip_ep_i   (flip_ep),
        .setup_clr_i (setup_i),
        .setup_ep_i  (setup_ep_i),
        .cfg_clr_i   (cfg_i),
        .tog_o       (tog),
        .iso_o       (iso)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rx_valid_i)      state_d = S_RX_RESP;
                else if (tx_start_i) state_d = S_TX_WAIT;
            end
            S_RX_RESP: state_d = S_IDLE;
            S_TX_WAIT: if (hs_done_i) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            verdict_q <= V_BAD;
            tx_ep_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && rx_valid_i)                verdict_q <= verdict_now;
            if (state_q == S_IDLE && !rx_valid_i && tx_start_i) tx_ep_q   <= tx_ep_i;
        end
    end

    always_comb begin
        hs    = HS_NONE;
        acc_o = 1'b0;
        dis_o = 1'b0;
        unique case (state_q)
            S_RX_RESP: begin
                unique case (verdict_q)
                    V_NEW:     begin hs = HS_ACK; acc_o = 1'b1; end
                    V_DUP:     begin hs = HS_ACK; dis_o = 1'b1; end
                    V_BAD,
                    V_BUSY:    begin hs = HS_NAK; dis_o = 1'b1; end
                    V_ISO_OK:  acc_o = 1'b1;
                    V_ISO_BAD: dis_o = 1'b1;
                    default:   dis_o = 1'b1;
                endcase
            end
            S_IDLE, S_TX_WAIT: hs = HS_NONE;
            default:           hs = HS_NONE;
        endcase
    end

    assign hs_o     = hs;
    assign tx_pid_o = (tog[tx_ep_i] && !iso[tx_ep_i]) ? PID_DATA1 : PID_DATA0;

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_o && dis_o));

    // R3
    new_flips_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && rx_valid_i && verdict_now == V_NEW && !setup_i && !cfg_i)
        |=> ($countones(tog ^ $past(tog)) == 1) && acc_o && hs_o == 2'b01);

    // R5
    dup_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && rx_valid_i && verdict_now == V_DUP && !setup_i && !cfg_i)
        |=> (tog == $past(tog)) && dis_o && hs_o == 2'b01);

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_TX_WAIT && !(hs_done_i && hs_ack_i) && !setup_i && !cfg_i)
        |=> $stable(tog));

    // R11
    rx_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_TX_WAIT) |=> !acc_o && !dis_o);
endmodule

// File: tb/ep_seq_sync_bench.sv
module ep_seq_sync_bench;
    localparam int N_EP = 4;
    localparam int EPW  = 2;
    localparam logic [3:0] D0 = 4'b0011;
    localparam logic [3:0] D1 = 4'b1011;
    // ep0 control, ep1 bulk, ep2 interrupt, ep3 isochronous
    localparam logic [7:0] TYPES = {2'b01, 2'b11, 2'b10, 2'b00};
    localparam int NV = 11;
    // {ep, pid, crc, rdy, hs, acc, dis, pid_after}
    localparam logic [15:0] VEC [NV] = '{
        {2'd1, D0,      1'b1, 1'b1, 2'd1, 1'b1, 1'b0, D1},
        {2'd1, D0,      1'b1, 1'b1, 2'd1, 1'b0, 1'b1, D1},
        {2'd1, D1,      1'b0, 1'b1, 2'd2, 1'b0, 1'b1, D1},
        {2'd1, D1,      1'b1, 1'b0, 2'd2, 1'b0, 1'b1, D1},
        {2'd1, D1,      1'b1, 1'b1, 2'd1, 1'b1, 1'b0, D0},
        {2'd2, D0,      1'b1, 1'b1, 2'd1, 1'b1, 1'b0, D1},
        {2'd3, D1,      1'b1, 1'b1, 2'd0, 1'b1, 1'b0, D0},
        {2'd3, D0,      1'b0, 1'b1, 2'd0, 1'b0, 1'b1, D0},
        {2'd0, D0,      1'b1, 1'b1, 2'd1, 1'b1, 1'b0, D1},
        {2'd1, 4'b0010, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, D0},
        {2'd1, D1,      1'b1, 1'b0, 2'd1, 1'b0, 1'b1, D0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic rx_valid = 0, crc = 0, rdy = 0, tx_start = 0, hs_done = 0, hs_ack = 0;
    logic setup = 0, cfg = 0;
    logic [EPW-1:0] rx_ep = 0, tx_ep = 0, setup_ep = 0;
    logic [3:0] pid = 0;
    logic [1:0] hs;
    logic acc, dis;
    logic [3:0] tx_pid;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    ep_seq_sync #(.N_EP(N_EP)) u_ep_seq_sync (
        .clk(clk), .rst(rst), .ep_types_i(TYPES),
        .rx_valid_i(rx_valid), .rx_ep_i(rx_ep), .rx_pid_i(pid),
        .rx_crc_ok_i(crc), .buf_rdy_i(rdy),
        .tx_start_i(tx_start), .tx_ep_i(tx_ep),
        .hs_done_i(hs_done), .hs_ack_i(hs_ack),
        .setup_i(setup), .setup_ep_i(setup_ep), .cfg_i(cfg),
        .hs_o(hs), .acc_o(acc), .dis_o(dis), .tx_pid_o(tx_pid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            1, 10:   return "R5";
            2, 9:    return "R4";
            3:       return "R6";
            6, 7:    return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic pid_of(input logic [EPW-1:0] ep, input logic [3:0] exp, input string tag);
        tx_ep = ep;
        #1;
        chk(tag, {12'd0, tx_pid}, {12'd0, exp});
    endtask

    task automatic rx(input logic [EPW-1:0] ep, input logic [3:0] p, input logic c, input logic r);
        @(negedge clk);
        rx_valid = 1; rx_ep = ep; pid = p; crc = c; rdy = r;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic tx(input logic [EPW-1:0] ep, input logic ack);
        @(negedge clk);
        tx_start = 1; tx_ep = ep;
        @(negedge clk);
        tx_start = 0; hs_done = 1; hs_ack = ack;
        @(negedge clk);
        hs_done = 0; hs_ack = 0;
    endtask

    initial begin
        #(8 * 100000);
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {13'd0, hs, acc, dis}, 16'd0);
        for (int e = 0; e < N_EP; e++) pid_of(EPW'(e), D0, "R1");

        for (int i = 0; i < NV; i++) begin
            rx(VEC[i][15:14], VEC[i][13:10], VEC[i][9], VEC[i][8]);
            chk(vtag(i), {12'd0, hs, acc, dis}, {12'd0, VEC[i][7:4]});
            pid_of(VEC[i][15:14], VEC[i][3:0], "R2");
        end
        // state: ep0=1 ep1=0 ep2=1 ep3=0

        // R7 setup on interrupt endpoint has no effect; on control it clears
        @(negedge clk); setup = 1; setup_ep = 2'd2;
        @(negedge clk); setup = 0;
        pid_of(2'd2, D1, "R7");
        @(negedge clk); setup = 1; setup_ep = 2'd0;
        @(negedge clk); setup = 0;
        pid_of(2'd0, D0, "R7");

        // R8 config clears bulk/interrupt, keeps control
        rx(2'd0, D0, 1, 1);
        rx(2'd1, D0, 1, 1);
        pid_of(2'd1, D1, "R3");
        @(negedge clk); cfg = 1;
        @(negedge clk); cfg = 0;
        pid_of(2'd1, D0, "R8");
        pid_of(2'd2, D0, "R8");
        pid_of(2'd0, D1, "R8");

        // R10 sender side
        tx(2'd1, 1'b0);
        pid_of(2'd1, D0, "R10");
        tx(2'd1, 1'b1);
        pid_of(2'd1, D1, "R10");
        tx(2'd3, 1'b1);
        pid_of(2'd3, D0, "R9");

        // R11 receive during transmit wait is ignored
        @(negedge clk); tx_start = 1; tx_ep = 2'd1;
        @(negedge clk); tx_start = 0;
        rx_valid = 1; rx_ep = 2'd1; pid = D1; crc = 1; rdy = 1;
        @(negedge clk); rx_valid = 0;
        chk("R11", {13'd0, hs, acc, dis}, 16'd0);
        hs_done = 1; hs_ack = 0;
        @(negedge clk); hs_done = 0;
        pid_of(2'd1, D1, "R11");

        // R1 reset clears a set bit
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        pid_of(2'd0, D0, "R1");
        pid_of(2'd1, D0, "R1");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule